// File: doc/BRIEF.md
# Streaming Set Reduction Engine

The block folds a continuous stream of tagged operands into one sum per set, using a single three-stage adder pipeline. One operand can arrive on every clock and nothing stalls. Operands that share a tag form a set. The set closes when a valid beat arrives with a different tag, or when the flush strobe is raised. While the partial sums of a closed set are still travelling through the adder, the operands of the next set are already being taken in.

A fixed eight-step routing schedule starts on each set close. It chooses what feeds the two adder ports on each cycle. A two-entry input buffer holds new operands while the adder is busy combining the three partial sums of the old set. A one-entry output buffer holds an old partial sum that is waiting for its partner. When the schedule ends, the old set's total is presented together with its tag.

Outside the schedule, each operand is added to the partial sum that is leaving the pipeline at that moment. Arithmetic is unsigned integer and wraps modulo 2^DATA_W.

Top module: `setred_top`

## Requirements
- R1: After reset, `outValid` stays low until the first set has been closed.
- R2: Each emitted `outSum` equals the sum modulo 2^DATA_W of every valid operand of one set, and `outTag` carries that set's tag.
- R3: Exactly one result is emitted per closed set, in the order the sets were closed, and two results are never on consecutive cycles.
- R4: A valid beat whose tag differs from the open set's tag closes that set and is the first operand of the new set. The result is visible 8 rising edges after the edge that samples that beat.
- R5: A flush cycle while a set is open closes it, and the result is visible 8 rising edges after the flush is sampled. A flush while no set is open produces no result.
- R6: A cycle with `inValid` low inside a set adds nothing to that set's sum.
- R7: A set close (tag change or flush) must come at least 8 cycles after the previous close. Sets of 8 or more back-to-back operands always meet this.
- R8: `flush` and `inValid` are never high in the same cycle.
- R9: The adder pipeline returns each sum exactly 3 cycles after its operands are applied.
- R10: A valid beat that arrives while no set is open opens a set with its tag. This includes a beat that arrives while the previous set's fold is still running.
- R11: Sets of 8 or more operands may follow one another with no idle cycle and with random lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand beat present |
| inData | input | DATA_W | Operand value |
| inTag | input | TAG_W | Set tag of the operand |
| flush | input | 1 | Close the open set without starting a new one |
| outValid | output | 1 | Result strobe, one cycle |
| outSum | output | DATA_W | Total of the completed set |
| outTag | output | TAG_W | Tag of the completed set |

## Verification
The bench builds the block with DATA_W = 16 and TAG_W = 4. Random 16-bit operands then make per-set totals wrap often, and a directed set of all-ones words lands on a known wrapped value. The 4-bit tag space makes reused and neighbouring tags common, including the same tag on both sides of a flush. Random set lengths from 8 to 20, optional gap cycles and flushes mixed into back-to-back traffic place schedule starts against every phase of the pipeline.

// File: rtl/setred_pkg.sv
package setred_pkg;

  // Fixed adder depth; the eight-step schedule below is built around it.
  localparam int ADD_LAT   = 3;
  localparam int SCHED_LEN = 8;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_IN,
    SRC_IB0,
    SRC_IB1,
    SRC_OB,
    SRC_PIPE
  } srcSel_e;

  typedef struct packed {
    srcSel_e selA;
    srcSel_e selB;
    logic    wrIb0;
    logic    wrIb1;
    logic    wrOb;
    logic    emit;
    logic    foldStart;
  } ctrlStrobe_t;

endpackage

// File: rtl/setred_ctrl.sv
module setred_ctrl
  import setred_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  input  logic             flush,
  output ctrlStrobe_t      strb,
  output logic [TAG_W-1:0] foldTag
);

  localparam int STEP_W = $clog2(SCHED_LEN + 1);
  localparam logic [STEP_W-1:0] IDLE = STEP_W'(SCHED_LEN);

  logic              setOpen;
  logic [TAG_W-1:0]  curTag;
  logic [STEP_W-1:0] stepReg;
  logic [STEP_W-1:0] stepNow;
  logic              trigger;

  always_comb begin
    trigger = setOpen && ((inValid && (inTag != curTag)) || flush);
    stepNow = trigger ? '0 : stepReg;
    strb           = '0;
    strb.selA      = SRC_IN;
    strb.selB      = SRC_PIPE;
    strb.foldStart = trigger;
    case (int'(stepNow))
      0: begin strb.selA = SRC_ZERO; strb.selB = SRC_ZERO; strb.wrIb0 = 1'b1; strb.wrOb = 1'b1; end
      1: begin strb.selA = SRC_OB;   strb.selB = SRC_PIPE; strb.wrIb1 = 1'b1; end
      2: begin strb.selA = SRC_IB0;  strb.selB = SRC_IB1;  strb.wrIb0 = 1'b1; strb.wrOb = 1'b1; end
      3: begin strb.selA = SRC_IB0;  strb.selB = SRC_IN;   end
      4: begin strb.selA = SRC_PIPE; strb.selB = SRC_OB;   strb.wrIb0 = 1'b1; end
      5, 6: begin strb.selA = SRC_IB0; strb.selB = SRC_PIPE; strb.wrIb0 = 1'b1; end
      7: begin strb.selA = SRC_IB0;  strb.selB = SRC_IN;   strb.emit = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setOpen <= 1'b0;
      curTag  <= '0;
      foldTag <= '0;
      stepReg <= IDLE;
    end else if (trigger) begin
      stepReg <= STEP_W'(1);
      foldTag <= curTag;
      if (flush) setOpen <= 1'b0;
      else       curTag  <= inTag;
    end else begin
      if (stepReg != IDLE) stepReg <= stepReg + 1'b1;
      if (inValid && !setOpen) begin
        setOpen <= 1'b1;
        curTag  <= inTag;
      end
    end
  end

  // R7: a close may only start while no schedule is running
  a_r7_close_spacing: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (stepReg == IDLE));

  // R8: flush never shares a cycle with an operand
  a_r8_flush_alone: assert property (@(posedge clk) disable iff (!rstN)
    !(flush && inValid));

endmodule

// File: rtl/setred_dp.sv
module setred_dp
  import setred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  foldTag,
  output logic              outValid,
  output logic [DATA_W-1:0] outSum,
  output logic [TAG_W-1:0]  outTag
);

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] ib0, ib1, ob;
  logic [DATA_W-1:0] portA, portB, sumNow, pipeOut;
  logic [DATA_W-1:0] stage [ADD_LAT];
  logic [1:0]        warm;

  function automatic logic [DATA_W-1:0] pick(
    input srcSel_e           s,
    input logic [DATA_W-1:0] xv,
    input logic [DATA_W-1:0] i0,
    input logic [DATA_W-1:0] i1,
    input logic [DATA_W-1:0] ov,
    input logic [DATA_W-1:0] pv
  );
    case (s)
      SRC_IN:   return xv;
      SRC_IB0:  return i0;
      SRC_IB1:  return i1;
      SRC_OB:   return ov;
      SRC_PIPE: return pv;
      default:  return '0;
    endcase
  endfunction

  assign operand = inValid ? inData : '0;
  assign pipeOut = stage[ADD_LAT-1];
  assign portA   = pick(strb.selA, operand, ib0, ib1, ob, pipeOut);
  assign portB   = pick(strb.selB, operand, ib0, ib1, ob, pipeOut);
  assign sumNow  = portA + portB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= sumNow;
  end

  for (genvar g = 1; g < ADD_LAT; g++) begin : gDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else       stage[g] <= stage[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ib0 <= '0; ib1 <= '0; ob <= '0;
      outValid <= 1'b0; outSum <= '0; outTag <= '0;
      warm <= '0;
    end else begin
      if (strb.wrIb0) ib0 <= operand;
      if (strb.wrIb1) ib1 <= operand;
      if (strb.wrOb)  ob  <= pipeOut;
      outValid <= strb.emit;
      if (strb.emit) begin
        outSum <= pipeOut;
        outTag <= foldTag;
      end
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // R9: each adder result leaves the pipeline three cycles later
  a_r9_adder_latency: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (pipeOut == $past(sumNow, 3)));

  // R4: a started schedule reaches its emit step seven cycles on
  a_r4_emit_after_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.foldStart |-> ##7 strb.emit);

endmodule

// File: rtl/setred_top.sv
module setred_top
  import setred_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              flush,
  output logic              outValid,
  output logic [DATA_W-1:0] outSum,
  output logic [TAG_W-1:0]  outTag
);

  ctrlStrobe_t      strb;
  logic [TAG_W-1:0] foldTag;

  setred_ctrl #(.TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
    .flush(flush), .strb(strb), .foldTag(foldTag)
  );

  setred_dp #(.DATA_W(DATA_W), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inValid(inValid),
    .inData(inData), .foldTag(foldTag), .outValid(outValid),
    .outSum(outSum), .outTag(outTag)
  );

  // R4 / R5: a result always follows a set close by eight edges
  a_r4_result_delay: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strb.foldStart, 8));

  // R3: results are never back to back
  a_r3_result_spacing: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: tb/setred_top_test.sv
module setred_top_test;

  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid, flush;
  logic [DATA_W-1:0] inData;
  logic [TAG_W-1:0]  inTag;
  logic              outValid;
  logic [DATA_W-1:0] outSum;
  logic [TAG_W-1:0]  outTag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic              mOpen;
  logic [TAG_W-1:0]  mTag;
  logic [DATA_W-1:0] mSum;
  logic [TAG_W+DATA_W-1:0] expQ[$];

  always #5 clk = ~clk;

  setred_top #(.DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inTag(inTag), .flush(flush), .outValid(outValid),
    .outSum(outSum), .outTag(outTag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [DATA_W-1:0] addWrap(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  // Reference model: runs on each driven beat, independent of the design
  task automatic driveBeat(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    inValid = 1'b1; flush = 1'b0; inTag = t; inData = d;
    if (mOpen && t != mTag) begin
      expQ.push_back({mTag, mSum});
      mSum = '0;
    end
    if (!mOpen || t != mTag) begin
      mOpen = 1'b1; mTag = t; mSum = '0;
    end
    mSum = addWrap(mSum, d);
  endtask

  task automatic driveIdle();
    inValid = 1'b0; flush = 1'b0;
  endtask

  task automatic driveFlush();
    inValid = 1'b0; flush = 1'b1;
    if (mOpen) begin
      expQ.push_back({mTag, mSum});
      mOpen = 1'b0; mSum = '0;
    end
  endtask

  task automatic sendBeat(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    @(negedge clk); driveBeat(t, d);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); driveIdle(); end
  endtask

  // R2 / R3: every result is compared, in order, against the model queue
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected result", outSum, 0);
      end else begin
        logic [TAG_W+DATA_W-1:0] e;
        e = expQ.pop_front();
        check(outTag == e[TAG_W+DATA_W-1:DATA_W], "R2", "result tag",
              outTag, e[TAG_W+DATA_W-1:DATA_W]);
        check(outSum == e[DATA_W-1:0], "R2", "result sum", outSum, e[DATA_W-1:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not end", 0, 1);
    finishRun();
  end

  initial begin
    bit quiet;
    int nSets;
    logic [TAG_W-1:0] tg;
    void'($urandom(32'd2718));
    mOpen = 1'b0; mTag = '0; mSum = '0;
    rstN = 1'b0; inValid = 1'b0; flush = 1'b0; inData = '0; inTag = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;

    // R1 and R5: flush with nothing open is ignored, no result appears
    @(negedge clk); driveFlush();
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); driveIdle();
      if (outValid) quiet = 1'b0;
    end
    check(quiet, "R1", "no result before any set closes", !quiet, 0);
    check(quiet, "R5", "flush with no open set", !quiet, 0);

    // R4: set 3 = 1..8, then tag 5 closes it; result after exactly 8 edges
    for (int i = 1; i <= 8; i++) sendBeat(4'd3, DATA_W'(i));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 7) check(outValid == 1'b0, "R4", "early result", outValid, 0);
      if (i == 8) begin
        check(outValid == 1'b1, "R4", "result strobe timing", outValid, 1);
        check(outSum == 16'd36, "R4", "first set total", outSum, 36);
      end
      driveBeat(4'd5, DATA_W'(100 + i));
    end

    // R5: flush closes set 5; result after exactly 8 edges
    @(negedge clk); driveFlush();
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk); driveIdle();
      if (i == 7) check(outValid == 1'b0, "R5", "early flush result", outValid, 0);
      if (i == 8) check(outValid == 1'b1 && outTag == 4'd5, "R5", "flush result strobe",
                        {outValid, outTag}, {1'b1, 4'd5});
    end

    // R2: all-ones set wraps to 0xFFF8
    for (int i = 0; i < 8; i++) sendBeat(4'd2, 16'hFFFF);
    // R10: flush, then same tag reopens at once while the fold runs
    @(negedge clk); driveFlush();
    for (int i = 0; i < 9; i++) begin
      sendBeat(4'd2, DATA_W'(16'h1000 + i));
      // R6: gap cycles inside the set add nothing
      if (i == 1 || i == 5) begin @(negedge clk); driveIdle(); end
    end
    // R11: back-to-back sets of exactly 8
    for (int i = 0; i < 8; i++) sendBeat(4'd9, DATA_W'(16'h0F0F ^ i));
    for (int i = 0; i < 8; i++) sendBeat(4'd10, DATA_W'(16'h8000 + 3 * i));
    @(negedge clk); driveFlush();
    idleCycles(12);
    check(expQ.size() == 0, "R3", "directed results drained", expQ.size(), 0);

    // R11 / R2 / R3: random back-to-back sets of length 8..20
    tg = 4'd0;
    nSets = 60;
    for (int s = 0; s < nSets; s++) begin
      int len;
      len = 8 + int'($urandom % 13);
      tg = tg + TAG_W'(1 + ($urandom % 15));
      for (int k = 0; k < len; k++) begin
        sendBeat(tg, DATA_W'($urandom));
        if (($urandom % 8) == 0) begin @(negedge clk); driveIdle(); end  // R6
      end
      if (($urandom % 6) == 0) begin
        @(negedge clk); driveFlush();
        idleCycles(int'($urandom % 4));
      end
    end
    @(negedge clk); driveFlush();
    idleCycles(15);
    check(expQ.size() == 0, "R3", "one result per set, all drained", expQ.size(), 0);
    finishRun();
  end

endmodule